// File: doc/BRIEF.md
# Opcode Fetch and Interrupt Arbiter

This block is the front end of an 8-bit processor with a 16-bit address bus. At every instruction boundary it makes one choice. It can start an ordinary opcode fetch, enter the non-maskable interrupt sequence, or enter one of three maskable interrupt sequences. The choice is returned as a one-hot code that is valid for one clock, and the bus strobes for that cycle are driven along with it. The block also owns the program counter, the halt state and the memory-refresh counter pair (the vector base register and the 7-bit refresh counter).

Three request inputs drive the sequencer around the block: `boundary`, `refresh` and `halt_req`. All outputs are registered, so they show the effect of a request one clock after it is sampled. Every strobe is cleared on each clock unless a new request asserts it again. Two write enables load the base register and the refresh counter from a shared data input.

Top module: `opfetch_arbiter`

## Requirements
- R1: While `rst` is high at a clock edge, the program counter, halt flag, base register and refresh counter are cleared, and all strobes and `seq_o` read zero on the next cycle.
- R2: At a boundary with no accepted interrupt, the old program counter is placed on `addr_o` and `m1_o`, `mreq_o` and `rd_o` are high. The counter advances by one, wrapping from 0xFFFF to 0x0000, and `seq_o` is 5'b00001 (bit 0).
- R3: A rising edge on `nmi_pin` sets a pending flag that stays set until a boundary accepts it. If the pin is held high, it does not set the flag again.
- R4: A pending NMI beats a pending INT. On acceptance `seq_o` is 5'b00010 (bit 1), the program counter is placed on `addr_o` with `m1_o`, `mreq_o` and `rd_o` high, and the counter does not advance.
- R5: `int_pin` is sampled as a level on every clock, and the boundary uses the value from the previous clock. If it was high and `iff1` is high, the INT entry is taken with no strobes and no counter change. `seq_o` is bit 2 for mode 0, bit 3 for mode 1, and bit 4 for mode 2 or 3 (`im` = 2'b11 is treated as mode 2).
- R6: With `iff1` low, a pending INT is ignored and the boundary performs an ordinary fetch as in R2.
- R7: `halt_req` decrements the program counter by one, with wrap, and sets `halt_o`. An ordinary fetch leaves `halt_o` set.
- R8: When an NMI or INT is accepted while `halt_o` is set, `halt_o` clears and the program counter advances by one before it is used.
- R9: A refresh request puts {base, counter} on `addr_o` with `mreq_o` and `rfsh_o` high and `m1_o`/`rd_o` low. The low 7 bits of the counter then increment and wrap, and bit 7 keeps its value.
- R10: Strobes and `seq_o` last one cycle. In a cycle with no boundary or refresh request, all of them read zero.
- R11: If several requests coincide, `boundary` wins over `refresh`, and `refresh` wins over `halt_req`. A request that loses has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| nmi_pin | input | 1 | Non-maskable interrupt line, edge-captured |
| int_pin | input | 1 | Maskable interrupt line, level-sampled |
| iff1 | input | 1 | Interrupt enable flip-flop |
| im | input | 2 | Interrupt mode (0, 1, 2; 3 acts as 2) |
| boundary | input | 1 | Instruction boundary: arbitrate and fetch |
| refresh | input | 1 | Refresh slot request |
| halt_req | input | 1 | Halt instruction executed |
| wr_base | input | 1 | Load base register from `reg_din` |
| wr_rcnt | input | 1 | Load refresh counter from `reg_din` |
| reg_din | input | 8 | Data for register loads |
| addr_o | output | 16 | Address bus |
| m1_o | output | 1 | Opcode fetch cycle strobe |
| mreq_o | output | 1 | Memory request strobe |
| rd_o | output | 1 | Read strobe |
| rfsh_o | output | 1 | Refresh strobe |
| halt_o | output | 1 | Halted state |
| pc_o | output | 16 | Program counter |
| seq_o | output | 5 | One-hot next sequence: fetch, NMI, IM0, IM1, IM2 |

## Verification
The assertions assume the sequencer raises `boundary`, `refresh` and `halt_req` only as one-cycle pulses and never loads the refresh counter in the same cycle as a refresh request. Under those conditions the per-cycle strobe patterns and the behaviour of the NMI pending flag hold. The bench drives every request for exactly one clock on the falling edge. It changes the interrupt pins at least one clock before the boundary that should see them, so the level sampling and the edge capture are each exercised on their own. It keeps register loads in cycles of their own.

// File: rtl/opfetch_arbiter_pkg.sv
package opfetch_arbiter_pkg;
   localparam int SEQ_N = 5;
   typedef enum int unsigned {
      SEQ_FETCH = 0,
      SEQ_NMI   = 1,
      SEQ_IM0   = 2,
      SEQ_IM1   = 3,
      SEQ_IM2   = 4
   } seq_idx_e;
   typedef struct packed {
      logic m1;
      logic mreq;
      logic rd;
      logic rfsh;
   } strobe_t;
endpackage

// File: rtl/opfetch_irq_latch.sv
module opfetch_irq_latch (
   input  logic clk,
   input  logic rst,
   input  logic nmi_pin,
   input  logic int_pin,
   input  logic nmi_clr,
   output logic nmi_pend,
   output logic int_lvl
);
   logic nmi_prev;
   logic nmi_rise;

   assign nmi_rise = nmi_pin & ~nmi_prev;

   always_ff @(posedge clk) begin
      if (rst) begin
         nmi_prev <= 1'b0;
         nmi_pend <= 1'b0;
         int_lvl  <= 1'b0;
      end else begin
         nmi_prev <= nmi_pin;
         nmi_pend <= (nmi_pend & ~nmi_clr) | nmi_rise;
         int_lvl  <= int_pin;
      end
   end

   assert_nmi_capture_R3: assert property (@(posedge clk) disable iff (rst)
      (nmi_pin && !nmi_prev) |=> nmi_pend);
   assert_nmi_sticky_R3: assert property (@(posedge clk) disable iff (rst)
      (nmi_pend && !nmi_clr) |=> nmi_pend);
endmodule

// File: rtl/opfetch_refresh.sv
module opfetch_refresh #(
   parameter int DATA_W = 8,
   parameter int RCNT_W = 7
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_base,
   input  logic              wr_rcnt,
   input  logic [DATA_W-1:0] din,
   input  logic              step,
   output logic [2*DATA_W-1:0] ir_addr
);
   logic [DATA_W-1:0] base_q;
   logic [DATA_W-1:0] rcnt_q;
   logic [DATA_W-1:0] rcnt_nx;

   if (RCNT_W < 1 || RCNT_W > DATA_W) begin : g_bad_rcnt
      $error("RCNT_W must be between 1 and DATA_W");
   end

   if (RCNT_W == DATA_W) begin : g_full
      assign rcnt_nx = rcnt_q + 1'b1;
   end else begin : g_part
      logic [RCNT_W-1:0] low_inc;
      assign low_inc = rcnt_q[RCNT_W-1:0] + 1'b1;
      assign rcnt_nx = {rcnt_q[DATA_W-1:RCNT_W], low_inc};
   end

   assign ir_addr = {base_q, rcnt_q};

   always_ff @(posedge clk) begin
      if (rst) begin
         base_q <= '0;
         rcnt_q <= '0;
      end else begin
         if (wr_base) base_q <= din;
         if (wr_rcnt)   rcnt_q <= din;
         else if (step) rcnt_q <= rcnt_nx;
      end
   end

   assert_rcnt_top_kept_R9: assert property (@(posedge clk) disable iff (rst)
      (step && !wr_rcnt) |=> rcnt_q[DATA_W-1] == $past(rcnt_q[DATA_W-1]) || RCNT_W == DATA_W);
   assert_base_hold_R9: assert property (@(posedge clk) disable iff (rst)
      !wr_base |=> base_q == $past(base_q));
endmodule

// File: rtl/opfetch_decide.sv
module opfetch_decide
   import opfetch_arbiter_pkg::*;
(
   input  logic             nmi_pend,
   input  logic             int_lvl,
   input  logic             iff1,
   input  logic [1:0]       im,
   output logic             take_nmi,
   output logic             take_int,
   output logic [SEQ_N-1:0] seq
);
   always_comb begin
      take_nmi = nmi_pend;
      take_int = ~nmi_pend & int_lvl & iff1;
      seq      = '0;
      if (take_nmi)         seq[SEQ_NMI] = 1'b1;
      else if (take_int) begin
         case (im)
            2'd0:    seq[SEQ_IM0] = 1'b1;
            2'd1:    seq[SEQ_IM1] = 1'b1;
            default: seq[SEQ_IM2] = 1'b1;
         endcase
      end else              seq[SEQ_FETCH] = 1'b1;
   end

   assert_decide_onehot_R4: assert final ($countones(seq) == 1);
endmodule

// File: rtl/opfetch_arbiter.sv
module opfetch_arbiter
   import opfetch_arbiter_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 16,
   parameter int RCNT_W = 7
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              nmi_pin,
   input  logic              int_pin,
   input  logic              iff1,
   input  logic [1:0]        im,
   input  logic              boundary,
   input  logic              refresh,
   input  logic              halt_req,
   input  logic              wr_base,
   input  logic              wr_rcnt,
   input  logic [DATA_W-1:0] reg_din,
   output logic [ADDR_W-1:0] addr_o,
   output logic              m1_o,
   output logic              mreq_o,
   output logic              rd_o,
   output logic              rfsh_o,
   output logic              halt_o,
   output logic [ADDR_W-1:0] pc_o,
   output logic [SEQ_N-1:0]  seq_o
);
   localparam logic [ADDR_W-1:0] PC_ONE = ADDR_W'(1);

   if (ADDR_W != 2 * DATA_W) begin : g_bad_width
      $error("ADDR_W must equal 2*DATA_W");
   end

   logic              nmi_pend, int_lvl, take_nmi, take_int;
   logic [SEQ_N-1:0]  dec_seq;
   logic [ADDR_W-1:0] ir_addr, pc_fix;
   logic              do_rfsh, do_halt;
   strobe_t           strb;

   assign do_rfsh = refresh & ~boundary;
   assign do_halt = halt_req & ~boundary & ~refresh;
   assign pc_fix  = halt_o ? pc_o + PC_ONE : pc_o;

   opfetch_irq_latch u_latch (
      .clk(clk), .rst(rst), .nmi_pin(nmi_pin), .int_pin(int_pin),
      .nmi_clr(boundary & take_nmi), .nmi_pend(nmi_pend), .int_lvl(int_lvl)
   );

   opfetch_decide u_decide (
      .nmi_pend(nmi_pend), .int_lvl(int_lvl), .iff1(iff1), .im(im),
      .take_nmi(take_nmi), .take_int(take_int), .seq(dec_seq)
   );

   opfetch_refresh #(.DATA_W(DATA_W), .RCNT_W(RCNT_W)) u_refresh (
      .clk(clk), .rst(rst), .wr_base(wr_base), .wr_rcnt(wr_rcnt),
      .din(reg_din), .step(do_rfsh), .ir_addr(ir_addr)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         pc_o   <= '0;
         addr_o <= '0;
         halt_o <= 1'b0;
         strb   <= '0;
         seq_o  <= '0;
      end else begin
         strb  <= '0;
         seq_o <= '0;
         if (boundary) begin
            seq_o <= dec_seq;
            if (take_nmi) begin
               addr_o <= pc_fix;
               pc_o   <= pc_fix;
               halt_o <= 1'b0;
               strb   <= '{m1: 1'b1, mreq: 1'b1, rd: 1'b1, rfsh: 1'b0};
            end else if (take_int) begin
               pc_o   <= pc_fix;
               halt_o <= 1'b0;
            end else begin
               addr_o <= pc_o;
               pc_o   <= pc_o + PC_ONE;
               strb   <= '{m1: 1'b1, mreq: 1'b1, rd: 1'b1, rfsh: 1'b0};
            end
         end else if (do_rfsh) begin
            addr_o <= ir_addr;
            strb   <= '{m1: 1'b0, mreq: 1'b1, rd: 1'b0, rfsh: 1'b1};
         end else if (do_halt) begin
            pc_o   <= pc_o - PC_ONE;
            halt_o <= 1'b1;
         end
      end
   end

   assign m1_o   = strb.m1;
   assign mreq_o = strb.mreq;
   assign rd_o   = strb.rd;
   assign rfsh_o = strb.rfsh;

   assert_seq_onehot0_R5: assert property (@(posedge clk) disable iff (rst)
      $onehot0(seq_o));
   assert_fetch_strobes_R2: assert property (@(posedge clk) disable iff (rst)
      seq_o[SEQ_FETCH] |-> (m1_o && mreq_o && rd_o && !rfsh_o && pc_o == addr_o + PC_ONE));
   assert_nmi_strobes_R4: assert property (@(posedge clk) disable iff (rst)
      seq_o[SEQ_NMI] |-> (m1_o && rd_o && pc_o == addr_o && !halt_o));
   assert_int_quiet_R5: assert property (@(posedge clk) disable iff (rst)
      (seq_o[SEQ_IM0] || seq_o[SEQ_IM1] || seq_o[SEQ_IM2]) |-> (!m1_o && !mreq_o && !rd_o && !halt_o));
   assert_halt_enter_R7: assert property (@(posedge clk) disable iff (rst)
      (halt_req && !boundary && !refresh) |=> (halt_o && pc_o == $past(pc_o) - PC_ONE));
   assert_refresh_shape_R9: assert property (@(posedge clk) disable iff (rst)
      rfsh_o |-> (mreq_o && !m1_o && !rd_o));
   assert_strobe_pulse_R10: assert property (@(posedge clk) disable iff (rst)
      (!boundary && !refresh) |=> (!mreq_o && seq_o == '0));
   assert_priority_R11: assert property (@(posedge clk) disable iff (rst)
      (boundary && (refresh || halt_req)) |=> (!rfsh_o && seq_o != '0));
endmodule

// File: tb/opfetch_arbiter_bench.sv
module opfetch_arbiter_bench;
   localparam int CLK_P = 10;

   logic clk = 1'b0, rst = 1'b1;
   logic nmi_pin = 0, int_pin = 0, iff1 = 0, boundary = 0, refresh = 0, halt_req = 0;
   logic wr_base = 0, wr_rcnt = 0;
   logic [1:0] im = 0;
   logic [7:0] reg_din = 0;
   logic [15:0] addr_o, pc_o;
   logic m1_o, mreq_o, rd_o, rfsh_o, halt_o;
   logic [4:0] seq_o;
   int n_chk = 0, n_fail = 0;

   always #(CLK_P/2) clk = ~clk;

   opfetch_arbiter u_opfetch_arbiter (
      .clk(clk), .rst(rst), .nmi_pin(nmi_pin), .int_pin(int_pin), .iff1(iff1), .im(im),
      .boundary(boundary), .refresh(refresh), .halt_req(halt_req),
      .wr_base(wr_base), .wr_rcnt(wr_rcnt), .reg_din(reg_din),
      .addr_o(addr_o), .m1_o(m1_o), .mreq_o(mreq_o), .rd_o(rd_o), .rfsh_o(rfsh_o),
      .halt_o(halt_o), .pc_o(pc_o), .seq_o(seq_o)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic req(input logic b, input logic r, input logic h);
      @(negedge clk); boundary = b; refresh = r; halt_req = h;
      @(negedge clk); boundary = 0; refresh = 0; halt_req = 0;
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   task automatic load(input logic is_base, input logic [7:0] v);
      @(negedge clk); wr_base = is_base; wr_rcnt = ~is_base; reg_din = v;
      @(negedge clk); wr_base = 0; wr_rcnt = 0;
   endtask

   task automatic do_reset();
      nmi_pin = 0; int_pin = 0; iff1 = 0; im = 0;
      @(negedge clk); rst = 1; idle(3); rst = 0;
   endtask

   task automatic t_reset();
      do_reset();
      check("R1 pc", pc_o, 0); check("R1 halt", halt_o, 0);
      check("R1 strobes", {m1_o, mreq_o, rd_o, rfsh_o}, 0); check("R1 seq", seq_o, 0);
      req(0, 1, 0);
      check("R1 refresh addr zero", addr_o, 16'h0000);
   endtask

   task automatic t_fetch();
      do_reset();
      for (int k = 0; k < 3; k++) begin
         req(1, 0, 0);
         check("R2 addr", addr_o, k); check("R2 pc", pc_o, k + 1);
         check("R2 strobes", {m1_o, mreq_o, rd_o, rfsh_o}, 4'b1110);
         check("R2 seq", seq_o, 5'b00001);
      end
      idle(1);
      check("R10 strobes drop", {m1_o, mreq_o, rd_o, rfsh_o, seq_o}, 0);
   endtask

   task automatic t_halt_wrap();
      do_reset();
      req(0, 0, 1);
      check("R7 pc back", pc_o, 16'hFFFF); check("R7 halt", halt_o, 1);
      req(1, 0, 0);
      check("R2 wrap addr", addr_o, 16'hFFFF); check("R2 wrap pc", pc_o, 16'h0000);
      check("R7 halt kept on fetch", halt_o, 1);
   endtask

   task automatic t_nmi();
      do_reset();
      req(1, 0, 0);
      @(negedge clk); nmi_pin = 1; int_pin = 1; iff1 = 1;
      idle(3);
      req(1, 0, 0);
      check("R4 nmi seq", seq_o, 5'b00010); check("R4 nmi addr", addr_o, 1);
      check("R4 nmi pc", pc_o, 1); check("R4 strobes", {m1_o, mreq_o, rd_o}, 3'b111);
      int_pin = 0; idle(2);
      req(1, 0, 0);
      check("R3 held pin no retrigger", seq_o, 5'b00001);
      check("R3 fetch pc", pc_o, 2);
      nmi_pin = 0;
   endtask

   task automatic t_int_modes();
      do_reset();
      iff1 = 1; int_pin = 1;
      for (int m = 0; m < 4; m++) begin
         im = m[1:0]; idle(1);
         req(1, 0, 0);
         check("R5 mode seq", seq_o, (m == 0) ? 5'b00100 : (m == 1) ? 5'b01000 : 5'b10000);
         check("R5 quiet", {m1_o, mreq_o, rd_o}, 0); check("R5 pc", pc_o, 0);
      end
      iff1 = 0;
      req(1, 0, 0);
      check("R6 disabled fetch", seq_o, 5'b00001); check("R6 pc", pc_o, 1);
      iff1 = 1; int_pin = 1; idle(1); int_pin = 0; idle(1);
      req(1, 0, 0);
      check("R5 dropped level", seq_o, 5'b00001);
   endtask

   task automatic t_halt_exit();
      do_reset();
      req(1, 0, 0);
      req(0, 0, 1);
      check("R7 pc", pc_o, 0);
      iff1 = 1; im = 1; int_pin = 1; idle(1);
      req(1, 0, 0);
      check("R8 int seq", seq_o, 5'b01000); check("R8 halt clear", halt_o, 0);
      check("R8 pc fix", pc_o, 1);
      int_pin = 0; idle(1);
      req(0, 0, 1);
      @(negedge clk); nmi_pin = 1; idle(2);
      req(1, 0, 0);
      check("R8 nmi seq", seq_o, 5'b00010); check("R8 nmi addr", addr_o, 1);
      check("R8 nmi halt clear", halt_o, 0);
      nmi_pin = 0;
   endtask

   task automatic t_refresh();
      do_reset();
      load(1, 8'h5A); load(0, 8'hFE);
      req(0, 1, 0);
      check("R9 addr", addr_o, 16'h5AFE);
      check("R9 strobes", {m1_o, mreq_o, rd_o, rfsh_o}, 4'b0101);
      req(0, 1, 0); check("R9 inc", addr_o, 16'h5AFF);
      req(0, 1, 0); check("R9 bit7 kept on wrap", addr_o, 16'h5A80);
      load(0, 8'h7F);
      req(0, 1, 0); req(0, 1, 0);
      check("R9 low wrap bit7 clear", addr_o, 16'h5A00);
   endtask

   task automatic t_priority();
      do_reset();
      req(1, 1, 1);
      check("R11 fetch wins", seq_o, 5'b00001); check("R11 no rfsh", rfsh_o, 0);
      check("R11 pc", pc_o, 1); check("R11 no halt", halt_o, 0);
      req(0, 1, 0);
      check("R11 counter untouched", addr_o, 16'h0000);
      req(0, 1, 1);
      check("R11 refresh wins", rfsh_o, 1); check("R11 halt ignored", halt_o, 0);
      check("R11 pc same", pc_o, 1);
   endtask

   initial begin
      #(CLK_P * 100000);
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      t_reset();
      t_fetch();
      t_halt_wrap();
      t_nmi();
      t_int_modes();
      t_halt_exit();
      t_refresh();
      t_priority();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule